// File: doc/BRIEF.md
# Two-Level Range Counter Predictor

This block predicts the write counter of a memory line so that decryption pads can be computed before the real counter arrives from memory. Every line in a page starts counting from a shared page root. Each line also keeps a 2-bit range code that names one of four adjacent windows above that root. Each window holds `WIN` counters, and `WIN` is a power of two. The first level reads the line's range code. The second level then emits `WIN` consecutive candidate counters from the chosen window, one per cycle. Together the four windows reach `4*WIN` counters above the root, while only `WIN` candidates are generated for each lookup.

When the real counter for a line has been fetched, it is presented on the verify port together with the page root. The block works out which window holds that counter and stores the result as the line's new range code. It reports whether the old code had already named that window. A counter below the root, or `4*WIN` or more above it, is flagged as out of range. The range table holds one 2-bit code per line for every page entry and is cleared by reset.

Top module: `ctr_range_pred`

## Requirements
- R1: After reset, `lk_ready_o` is 1, `cand_valid_o` and `vf_done_o` are 0, and every stored range code is 0, so the first lookup of any line predicts from the root.
- R2: A lookup accepted at a clock edge (`lk_valid_i` and `lk_ready_o` both 1) makes `cand_valid_o` high for exactly `WIN` consecutive cycles starting the next cycle. `cand_idx_o` counts 0 to `WIN-1`, `cand_last_o` is high only with index `WIN-1`, and `cand_valid_o` is low in the cycle after the last candidate.
- R3: Candidate k equals `root + r*WIN + k` modulo 2^`CTR_W`, where r is the line's stored range code (00, 01, 10 and 11 in increasing counter order), read in the cycle the lookup is accepted.
- R4: While candidates are being emitted, `lk_ready_o` is 0 and lookup requests are ignored: the stream in progress keeps its values and no second stream follows it.
- R5: A verify request produces `vf_done_o` high for exactly one cycle, in the cycle after the request. For `root <= ctr < root + 4*WIN`, `vf_range_o` is `floor((ctr-root)/WIN)` and that code becomes the line's stored range.
- R6: `vf_hit_o` is 1 only when the counter is in range and its window equals the range code the line held before this verify.
- R7: A counter below the root sets `vf_oor_o` to 1 and `vf_hit_o` to 0, and stores and reports range code 0.
- R8: A counter at `root + 4*WIN` or above sets `vf_oor_o` to 1 and `vf_hit_o` to 0, and stores and reports range code 3 (saturation).
- R9: A verify changes only the range code of its own (page, line). Other lines of the same page, and the same line of other pages, keep their codes.
- R10: A counter in the top window (for example `root + 4*WIN - 1`) is in range, stores code 3, and is produced by the next lookup of that line as candidate `WIN-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_page_i | input | PAGE_W | Page entry index of the lookup |
| lk_line_i | input | LINE_W | Line index within the page |
| lk_root_i | input | CTR_W | Page root counter for the lookup |
| lk_ready_o | output | 1 | High when a lookup can be accepted |
| cand_valid_o | output | 1 | Candidate counter valid |
| cand_ctr_o | output | CTR_W | Candidate counter value |
| cand_idx_o | output | IDX_W | Position of the candidate in its window |
| cand_last_o | output | 1 | Last candidate of the stream |
| vf_valid_i | input | 1 | Verify request carrying a fetched counter |
| vf_page_i | input | PAGE_W | Page entry index of the verify |
| vf_line_i | input | LINE_W | Line index of the verify |
| vf_root_i | input | CTR_W | Page root counter for the verify |
| vf_ctr_i | input | CTR_W | Fetched counter value |
| vf_done_o | output | 1 | Verify result valid |
| vf_range_o | output | 2 | Range code now stored for the line |
| vf_oor_o | output | 1 | Fetched counter outside the four windows |
| vf_hit_o | output | 1 | Old range code named the correct window |

## Verification
The assertions assume that reset is released before any request and that verify requests never arrive on consecutive cycles in a way that needs queuing; each request is seen once per high cycle. They also assume the root stays far enough from the top of the counter space that a stream does not wrap in a way that matters for the increment check. The stimulus keeps to this by driving every request for a single cycle between falling edges and by choosing roots whose windows stay below the wrap, apart from one vector near the top that stays below 2^32. A lookup and a verify of the same line in the same cycle are never driven together, so the ordering rule between them (the lookup reads the old code) is never in question.

// File: rtl/ctr_range_pred_pkg.sv
package ctr_range_pred_pkg;
  localparam int unsigned RANGE_W    = 2;
  localparam int unsigned NUM_RANGES = 1 << RANGE_W;
  typedef logic [RANGE_W-1:0] range_t;
endpackage

// File: rtl/ctr_range_table.sv
module ctr_range_table
  import ctr_range_pred_pkg::*;
#(
  parameter int unsigned PAGES = 64,
  parameter int unsigned LINES = 16,
  localparam int unsigned PAGE_W = $clog2(PAGES),
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned ROW_W  = LINES * RANGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAGE_W-1:0] rd_a_page_i,
  input  logic [LINE_W-1:0] rd_a_line_i,
  output range_t            rd_a_range_o,
  input  logic [PAGE_W-1:0] rd_b_page_i,
  input  logic [LINE_W-1:0] rd_b_line_i,
  output range_t            rd_b_range_o,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  range_t            wr_range_i
);
  // one packed row of range codes per page entry
  logic [ROW_W-1:0] rows_q [PAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < PAGES; p++) rows_q[p] <= '0;
    end else if (wr_en_i) begin
      rows_q[wr_page_i][wr_line_i*RANGE_W +: RANGE_W] <= wr_range_i;
    end
  end

  assign rd_a_range_o = rows_q[rd_a_page_i][rd_a_line_i*RANGE_W +: RANGE_W];
  assign rd_b_range_o = rows_q[rd_b_page_i][rd_b_line_i*RANGE_W +: RANGE_W];
endmodule

// File: rtl/ctr_range_calc.sv
module ctr_range_calc
  import ctr_range_pred_pkg::*;
#(
  parameter int unsigned CTR_W = 32,
  parameter int unsigned WIN   = 4,
  localparam int unsigned WIN_SH = $clog2(WIN)
) (
  input  logic [CTR_W-1:0] root_i,
  input  logic [CTR_W-1:0] ctr_i,
  input  range_t           old_range_i,
  output range_t           new_range_o,
  output logic             oor_o,
  output logic             hit_o
);
  logic [CTR_W-1:0] diff;
  logic             below, above;
  range_t           win_idx;

  always_comb begin
    diff    = ctr_i - root_i;
    below   = ctr_i < root_i;
    above   = |(diff >> (WIN_SH + RANGE_W));
    win_idx = diff[WIN_SH +: RANGE_W];
    oor_o   = below | above;
    if (below)      new_range_o = '0;
    else if (above) new_range_o = range_t'(NUM_RANGES - 1);
    else            new_range_o = win_idx;
    hit_o   = !oor_o && (win_idx == old_range_i);
  end
endmodule

// File: rtl/ctr_cand_gen.sv
module ctr_cand_gen #(
  parameter int unsigned CTR_W = 32,
  parameter int unsigned WIN   = 4,
  localparam int unsigned IDX_W = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CTR_W-1:0] base_i,
  output logic             busy_o,
  output logic [CTR_W-1:0] cand_ctr_o,
  output logic [IDX_W-1:0] cand_idx_o,
  output logic             cand_last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [CTR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        base_q <= base_i;
      end
    end else if (idx_q == LAST_IDX) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign cand_idx_o  = idx_q;
  assign cand_ctr_o  = base_q + CTR_W'(idx_q);
  assign cand_last_o = busy_q && (idx_q == LAST_IDX);
endmodule

// File: rtl/ctr_range_pred.sv
module ctr_range_pred
  import ctr_range_pred_pkg::*;
#(
  parameter int unsigned CTR_W = 32,
  parameter int unsigned WIN   = 4,
  parameter int unsigned PAGES = 64,
  parameter int unsigned LINES = 16,
  localparam int unsigned PAGE_W = $clog2(PAGES),
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam int unsigned IDX_W  = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int unsigned WIN_SH = $clog2(WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [PAGE_W-1:0] lk_page_i,
  input  logic [LINE_W-1:0] lk_line_i,
  input  logic [CTR_W-1:0]  lk_root_i,
  output logic              lk_ready_o,
  output logic              cand_valid_o,
  output logic [CTR_W-1:0]  cand_ctr_o,
  output logic [IDX_W-1:0]  cand_idx_o,
  output logic              cand_last_o,
  input  logic              vf_valid_i,
  input  logic [PAGE_W-1:0] vf_page_i,
  input  logic [LINE_W-1:0] vf_line_i,
  input  logic [CTR_W-1:0]  vf_root_i,
  input  logic [CTR_W-1:0]  vf_ctr_i,
  output logic              vf_done_o,
  output logic [1:0]        vf_range_o,
  output logic              vf_oor_o,
  output logic              vf_hit_o
);
  range_t           lk_range, vf_old_range, vf_new_range;
  logic             vf_oor, vf_hit, busy;
  logic [CTR_W-1:0] lk_base;

  ctr_range_table #(.PAGES(PAGES), .LINES(LINES)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_a_page_i (lk_page_i),
    .rd_a_line_i (lk_line_i),
    .rd_a_range_o(lk_range),
    .rd_b_page_i (vf_page_i),
    .rd_b_line_i (vf_line_i),
    .rd_b_range_o(vf_old_range),
    .wr_en_i     (vf_valid_i),
    .wr_page_i   (vf_page_i),
    .wr_line_i   (vf_line_i),
    .wr_range_i  (vf_new_range)
  );

  ctr_range_calc #(.CTR_W(CTR_W), .WIN(WIN)) u_calc (
    .root_i     (vf_root_i),
    .ctr_i      (vf_ctr_i),
    .old_range_i(vf_old_range),
    .new_range_o(vf_new_range),
    .oor_o      (vf_oor),
    .hit_o      (vf_hit)
  );

  // first level: offset the root by the selected window
  assign lk_base = lk_root_i + (CTR_W'(lk_range) << WIN_SH);

  ctr_cand_gen #(.CTR_W(CTR_W), .WIN(WIN)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (lk_valid_i),
    .base_i     (lk_base),
    .busy_o     (busy),
    .cand_ctr_o (cand_ctr_o),
    .cand_idx_o (cand_idx_o),
    .cand_last_o(cand_last_o)
  );

  assign lk_ready_o   = !busy;
  assign cand_valid_o = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vf_done_o  <= 1'b0;
      vf_range_o <= '0;
      vf_oor_o   <= 1'b0;
      vf_hit_o   <= 1'b0;
    end else begin
      vf_done_o <= vf_valid_i;
      if (vf_valid_i) begin
        vf_range_o <= vf_new_range;
        vf_oor_o   <= vf_oor;
        vf_hit_o   <= vf_hit;
      end
    end
  end
endmodule

// File: rtl/ctr_range_pred_chk.sv
module ctr_range_pred_chk #(
  parameter int unsigned CTR_W = 32,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_valid_i,
  input logic             lk_ready_o,
  input logic             cand_valid_o,
  input logic [CTR_W-1:0] cand_ctr_o,
  input logic [IDX_W-1:0] cand_idx_o,
  input logic             cand_last_o,
  input logic             vf_valid_i,
  input logic             vf_done_o,
  input logic [1:0]       vf_range_o,
  input logic             vf_oor_o,
  input logic             vf_hit_o
);
  // R2
  cand_last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_last_o |-> cand_valid_o);
  // R2
  cand_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_last_o |=> !cand_valid_o);
  // R2
  cand_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_ready_o) |=> (cand_valid_o && cand_idx_o == '0));
  // R3
  cand_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_o && !cand_last_o) |=> (cand_valid_o && cand_ctr_o == $past(cand_ctr_o) + 1'b1));
  // R4
  cand_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_valid_o && !cand_last_o) |=> (cand_idx_o == $past(cand_idx_o) + 1'b1));
  // R5
  vf_done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vf_valid_i |=> vf_done_o);
  // R5
  vf_done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vf_valid_i |=> !vf_done_o);
  // R6
  vf_oor_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vf_done_o && vf_oor_o) |-> !vf_hit_o);
  // R8
  vf_oor_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vf_done_o && vf_oor_o) |-> (vf_range_o == 2'd0 || vf_range_o == 2'd3));
endmodule

bind ctr_range_pred ctr_range_pred_chk #(.CTR_W(CTR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/ctr_range_pred_tb.sv
module ctr_range_pred_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CTR_W = 32;
  localparam int WIN   = 4;
  localparam int PAGES = 64;
  localparam int LINES = 16;

  typedef struct packed {
    logic        is_vf;
    logic [5:0]  page;
    logic [3:0]  line;
    logic [31:0] root;
    logic [31:0] ctr;
    logic [31:0] exp;    // first candidate (lookup) or range code (verify)
    logic        exp_oor;
    logic        exp_hit;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  4'd0,  32'd1000, 32'd0,    32'd1000, 1'b0, 1'b0}, // R1 code 0 after reset
    '{1'b1, 6'd0,  4'd0,  32'd1000, 32'd1009, 32'd2,    1'b0, 1'b0}, // R5 window 2
    '{1'b0, 6'd0,  4'd0,  32'd1000, 32'd0,    32'd1008, 1'b0, 1'b0}, // R3 offset window
    '{1'b1, 6'd0,  4'd0,  32'd1000, 32'd1010, 32'd2,    1'b0, 1'b1}, // R6 hit
    '{1'b1, 6'd0,  4'd1,  32'd1000, 32'd1015, 32'd3,    1'b0, 1'b0}, // R10 top window
    '{1'b0, 6'd0,  4'd1,  32'd1000, 32'd0,    32'd1012, 1'b0, 1'b0}, // R10 covers 1015
    '{1'b1, 6'd0,  4'd2,  32'd1000, 32'd1016, 32'd3,    1'b1, 1'b0}, // R8 saturate
    '{1'b0, 6'd0,  4'd2,  32'd1000, 32'd0,    32'd1012, 1'b0, 1'b0}, // R8 stored 3
    '{1'b1, 6'd0,  4'd2,  32'd1000, 32'd999,  32'd0,    1'b1, 1'b0}, // R7 below root
    '{1'b0, 6'd0,  4'd2,  32'd1000, 32'd0,    32'd1000, 1'b0, 1'b0}, // R7 stored 0
    '{1'b0, 6'd0,  4'd3,  32'd1000, 32'd0,    32'd1000, 1'b0, 1'b0}, // R9 neighbour line
    '{1'b0, 6'd1,  4'd0,  32'd500,  32'd0,    32'd500,  1'b0, 1'b0}, // R9 other page
    '{1'b1, 6'd63, 4'd15, 32'hFFFF_FFF0, 32'hFFFF_FFF5, 32'd1, 1'b0, 1'b0}, // R5 last entry
    '{1'b0, 6'd63, 4'd15, 32'hFFFF_FFF0, 32'd0, 32'hFFFF_FFF4, 1'b0, 1'b0}, // R3
    '{1'b1, 6'd0,  4'd0,  32'd1000, 32'd1003, 32'd0,    1'b0, 1'b0}, // R6 miss, back to 0
    '{1'b0, 6'd0,  4'd0,  32'd1000, 32'd0,    32'd1000, 1'b0, 1'b0}  // R5 rewrite seen
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [5:0]  lk_page_i = '0;
  logic [3:0]  lk_line_i = '0;
  logic [31:0] lk_root_i = '0;
  logic        lk_ready_o, cand_valid_o, cand_last_o;
  logic [31:0] cand_ctr_o;
  logic [1:0]  cand_idx_o;
  logic        vf_valid_i = 1'b0;
  logic [5:0]  vf_page_i = '0;
  logic [3:0]  vf_line_i = '0;
  logic [31:0] vf_root_i = '0;
  logic [31:0] vf_ctr_i = '0;
  logic        vf_done_o, vf_oor_o, vf_hit_o;
  logic [1:0]  vf_range_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ctr_range_pred #(.CTR_W(CTR_W), .WIN(WIN), .PAGES(PAGES), .LINES(LINES)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic do_verify(input vec_t v);
    @(negedge clk_i);
    vf_valid_i = 1'b1; vf_page_i = v.page; vf_line_i = v.line;
    vf_root_i = v.root; vf_ctr_i = v.ctr;
    @(negedge clk_i);
    vf_valid_i = 1'b0;
    chk(vf_done_o == 1'b1, "R5 done", 32'(vf_done_o), 1);
    chk(vf_range_o == v.exp[1:0], "R5 range", 32'(vf_range_o), v.exp);
    chk(vf_oor_o == v.exp_oor, "R7/R8 oor", 32'(vf_oor_o), 32'(v.exp_oor));
    chk(vf_hit_o == v.exp_hit, "R6 hit", 32'(vf_hit_o), 32'(v.exp_hit));
    @(negedge clk_i);
    chk(vf_done_o == 1'b0, "R5 single pulse", 32'(vf_done_o), 0);
  endtask

  // intrude: drive a second lookup at candidate index 1 (R4)
  task automatic do_lookup(input vec_t v, input bit intrude);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_page_i = v.page; lk_line_i = v.line; lk_root_i = v.root;
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    for (int k = 0; k < WIN; k++) begin
      chk(cand_valid_o == 1'b1, "R2 valid", 32'(cand_valid_o), 1);
      chk(cand_idx_o == 2'(k), "R2 idx", 32'(cand_idx_o), 32'(k));
      chk(cand_last_o == (k == WIN-1), "R2 last", 32'(cand_last_o), 32'(k == WIN-1));
      chk(cand_ctr_o == v.exp + 32'(k), "R3 cand", cand_ctr_o, v.exp + 32'(k));
      if (intrude) begin
        chk(lk_ready_o == 1'b0, "R4 ready low", 32'(lk_ready_o), 0);
        lk_valid_i = (k == 1); lk_page_i = 6'd1; lk_line_i = 4'd0; lk_root_i = 32'd500;
      end
      @(negedge clk_i);
    end
    lk_valid_i = 1'b0;
    chk(cand_valid_o == 1'b0, "R2/R4 stream ended", 32'(cand_valid_o), 0);
    chk(lk_ready_o == 1'b1, "R2 ready again", 32'(lk_ready_o), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(lk_ready_o == 1'b1, "R1 ready", 32'(lk_ready_o), 1);
    chk(cand_valid_o == 1'b0, "R1 cand idle", 32'(cand_valid_o), 0);
    chk(vf_done_o == 1'b0, "R1 vf idle", 32'(vf_done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_vf) do_verify(VECS[i]);
      else               do_lookup(VECS[i], 1'b0);
    end

    // R4: lookup of line 1 (code 3, base 1012) with an intruding request
    do_lookup('{1'b0, 6'd0, 4'd1, 32'd1000, 32'd0, 32'd1012, 1'b0, 1'b0}, 1'b1);
    repeat (2) @(negedge clk_i);
    chk(cand_valid_o == 1'b0, "R4 no second stream", 32'(cand_valid_o), 0);

    // R10: edge of top window, root+4*WIN-1
    do_verify('{1'b1, 6'd5, 4'd7, 32'd200, 32'd215, 32'd3, 1'b0, 1'b0});
    do_lookup('{1'b0, 6'd5, 4'd7, 32'd200, 32'd0, 32'd212, 1'b0, 1'b0}, 1'b0);

    // R1: reset mid-run clears stored codes
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    do_lookup('{1'b0, 6'd0, 4'd1, 32'd1000, 32'd0, 32'd1000, 1'b0, 1'b0}, 1'b0);

    report();
  end
endmodule